// File: doc/BRIEF.md
# Ping-Pong DMA Channel Pair Sequencer

This block sequences four DMA channel state machines arranged as two fixed pairs: channels 0 and 1 form pair 0, and channels 2 and 3 form pair 1. Each channel counts bytes down from a programmed block length and repeats the block a programmed number of times. When a pair is set to chained mode, a channel that finishes its last block hands the transfer to its partner without any software action. Software reloads the idle channel while its partner moves data, so the stream never pauses. The handoff works in both directions.

Each pair is configured on its own. One pair can ping-pong while the other runs both channels independently or sits unused. Software arms a channel with a one-cycle pulse, which captures that channel's block length and repeat count and sets its enable. A completing channel clears its own enable, so a chained partner continues only if software has re-armed it in the meantime.

The block has no data path. The byte-done strobe reports one byte moved per cycle from a simplified data mover. That mover never waits on this block, so no valid/ready handshake and no back-pressure exist at any port. All pins are plain control and status levels or strobes.

Top module: `dma_pair_chainer`

## Requirements
- R1: While reset is low, and in the first cycle after reset, every enable, busy, block-done, complete and pair-active output is 0.
- R2: An arm pulse on a channel that is not busy captures its block length and repeat count, and shows enabled one cycle later. An arm pulse on a busy channel is ignored: the running transfer keeps its length, and the enable still clears at completion.
- R3: In an independent pair, an enabled idle channel with its request high shows busy in the next cycle.
- R4: A busy channel counts one byte per cycle with byte-done high. Block-done pulses for one cycle after each block of the programmed length, so the first pulse appears block-length cycles after busy rises.
- R5: After repeat-count blocks, complete pulses in the same cycle as the last block-done, while busy and enabled both fall in that cycle.
- R6: Byte-done strobes on a channel that is not busy have no effect and produce no block-done pulse.
- R7: In a chained pair, when one channel completes and its partner is enabled, the partner shows busy in the next cycle with no request. This works from the lower to the higher channel and back.
- R8: In a chained pair, when a channel completes and its partner is not enabled, the pair stops and its active-valid output is 0 in the completion cycle.
- R9: The two channels of a chained pair are never busy together. A request on the idle channel while its partner is busy is ignored.
- R10: When both channels of an idle chained pair are enabled and requested in the same cycle, only the lower-numbered channel (even index) starts.
- R11: In an independent pair, both channels may be busy at once, and a channel's completion never starts its partner.
- R12: Pair active-valid is 1 while either channel is busy or being started. Active-select is 1 when the higher channel is busy or being started, so in the cycle of a chained handoff it already names the partner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pair_chain | input | NPAIR | Per pair: 1 chains the two channels, 0 runs them independently |
| ch_arm | input | 2*NPAIR | Per channel one-cycle arm pulse (loads config, sets enable) |
| cfg_blk | input | 2*NPAIR*BLK_W | Per channel block length in bytes, channel i at bits [i*BLK_W +: BLK_W] |
| cfg_rep | input | 2*NPAIR*REP_W | Per channel repeat count in blocks, channel i at bits [i*REP_W +: REP_W] |
| ch_req | input | 2*NPAIR | Per channel transfer request level |
| byte_done | input | 2*NPAIR | Per channel strobe: one byte moved this cycle |
| ch_enabled | output | 2*NPAIR | Per channel enable state |
| ch_busy | output | 2*NPAIR | Per channel transfer in progress |
| ch_blk_done | output | 2*NPAIR | Per channel one-cycle pulse at the end of each block |
| ch_cmpl | output | 2*NPAIR | Per channel one-cycle pulse at the end of the last block |
| pair_act_vld | output | NPAIR | Per pair: a channel is busy or starting |
| pair_act_sel | output | NPAIR | Per pair: 1 selects the higher channel as active |

## Verification
The properties assume two things about the inputs. First, a pair's chain setting is changed only while both of its channels are idle. Second, every arm carries a block length and repeat count of at least one. A zero value would wrap the down-counters, and flipping chain mode on two running channels would make them busy together legitimately. The stimulus keeps inside both assumptions: it sweeps block lengths 1 to 4 and repeat counts 1 to 3 with chaining off, and switches pair 0 to chained mode only after every channel has finished. Byte-done is held high throughout, so each run's timing follows from block length times repeat count.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  typedef enum logic {
    CH_IDLE = 1'b0,
    CH_RUN  = 1'b1
  } ch_state_e;

endpackage

// File: rtl/dpc_channel.sv
module dpc_channel
  import dpc_pkg::*;
#(
  parameter int BLK_W = 8,
  parameter int REP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [BLK_W-1:0] blk_len_in,
  input  logic [REP_W-1:0] rep_cnt_in,
  input  logic             start,
  input  logic             byte_done,
  output logic             enabled,
  output logic             busy,
  output logic             blk_done,
  output logic             cmpl
);

  localparam logic [BLK_W-1:0] BLK_ONE = BLK_W'(1);
  localparam logic [REP_W-1:0] REP_ONE = REP_W'(1);

  ch_state_e        state;
  logic [BLK_W-1:0] blk_len_q;
  logic [REP_W-1:0] rep_len_q;
  logic [BLK_W-1:0] byte_left;
  logic [REP_W-1:0] blk_left;
  logic             last_byte;
  logic             last_blk;

  assign last_byte = (byte_left == BLK_ONE);
  assign last_blk  = (blk_left == REP_ONE);
  assign busy      = (state == CH_RUN);

  // Configuration capture: only accepted while the channel is idle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_len_q <= '0;
      rep_len_q <= '0;
    end else if (arm && state == CH_IDLE) begin
      blk_len_q <= blk_len_in;
      rep_len_q <= rep_cnt_in;
    end
  end

  // Byte / block down-counters and run state.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= CH_IDLE;
      enabled   <= 1'b0;
      byte_left <= '0;
      blk_left  <= '0;
      blk_done  <= 1'b0;
      cmpl      <= 1'b0;
    end else begin
      blk_done <= 1'b0;
      cmpl     <= 1'b0;
      case (state)
        CH_IDLE: begin
          if (arm) begin
            enabled <= 1'b1;
          end
          if (start && enabled) begin
            state     <= CH_RUN;
            byte_left <= blk_len_q;
            blk_left  <= rep_len_q;
          end
        end
        CH_RUN: begin
          if (byte_done) begin
            if (last_byte) begin
              blk_done <= 1'b1;
              if (last_blk) begin
                cmpl    <= 1'b1;
                enabled <= 1'b0;
                state   <= CH_IDLE;
              end else begin
                blk_left  <= blk_left - REP_ONE;
                byte_left <= blk_len_q;
              end
            end else begin
              byte_left <= byte_left - BLK_ONE;
            end
          end
        end
        default: state <= CH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dpc_pair_seq.sv
module dpc_pair_seq (
  input  logic       chain,
  input  logic [1:0] req,
  input  logic [1:0] en,
  input  logic [1:0] busy,
  input  logic [1:0] cmpl,
  output logic [1:0] start,
  output logic       act_vld,
  output logic       act_sel
);

  logic [1:0] hand;
  logic [1:0] ready;
  logic [1:0] solo;
  logic       pair_free;

  always_comb begin
    // Partner takeover in the cycle the finishing channel drops busy.
    hand[0]   = chain & cmpl[1] & en[0];
    hand[1]   = chain & cmpl[0] & en[1];
    ready     = req & en & ~busy;
    pair_free = ~(|busy) & ~(|hand);
    if (chain) begin
      solo[0] = ready[0] & pair_free;
      solo[1] = ready[1] & pair_free & ~ready[0];
    end else begin
      solo = ready;
    end
    start   = hand | solo;
    act_vld = (|busy) | (|start);
    act_sel = busy[1] | start[1];
  end

endmodule

// File: rtl/dma_pair_chainer.sv
module dma_pair_chainer #(
  parameter int NPAIR = 2,
  parameter int BLK_W = 8,
  parameter int REP_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NPAIR-1:0]           pair_chain,
  input  logic [2*NPAIR-1:0]         ch_arm,
  input  logic [2*NPAIR*BLK_W-1:0]   cfg_blk,
  input  logic [2*NPAIR*REP_W-1:0]   cfg_rep,
  input  logic [2*NPAIR-1:0]         ch_req,
  input  logic [2*NPAIR-1:0]         byte_done,
  output logic [2*NPAIR-1:0]         ch_enabled,
  output logic [2*NPAIR-1:0]         ch_busy,
  output logic [2*NPAIR-1:0]         ch_blk_done,
  output logic [2*NPAIR-1:0]         ch_cmpl,
  output logic [NPAIR-1:0]           pair_act_vld,
  output logic [NPAIR-1:0]           pair_act_sel
);

  localparam int NCH = 2 * NPAIR;

  logic [NCH-1:0] ch_start;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dpc_channel #(
      .BLK_W (BLK_W),
      .REP_W (REP_W)
    ) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .arm        (ch_arm[c]),
      .blk_len_in (cfg_blk[c*BLK_W +: BLK_W]),
      .rep_cnt_in (cfg_rep[c*REP_W +: REP_W]),
      .start      (ch_start[c]),
      .byte_done  (byte_done[c]),
      .enabled    (ch_enabled[c]),
      .busy       (ch_busy[c]),
      .blk_done   (ch_blk_done[c]),
      .cmpl       (ch_cmpl[c])
    );
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    dpc_pair_seq u_seq (
      .chain   (pair_chain[p]),
      .req     (ch_req[2*p +: 2]),
      .en      (ch_enabled[2*p +: 2]),
      .busy    (ch_busy[2*p +: 2]),
      .cmpl    (ch_cmpl[2*p +: 2]),
      .start   (ch_start[2*p +: 2]),
      .act_vld (pair_act_vld[p]),
      .act_sel (pair_act_sel[p])
    );
  end

endmodule

// File: rtl/dpc_checker.sv
module dpc_checker #(
  parameter int NPAIR = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NPAIR-1:0]     pair_chain,
  input logic [2*NPAIR-1:0]   ch_req,
  input logic [2*NPAIR-1:0]   ch_enabled,
  input logic [2*NPAIR-1:0]   ch_busy,
  input logic [2*NPAIR-1:0]   ch_blk_done,
  input logic [2*NPAIR-1:0]   ch_cmpl,
  input logic [NPAIR-1:0]     pair_act_vld,
  input logic [NPAIR-1:0]     pair_act_sel
);

  for (genvar i = 0; i < 2*NPAIR; i++) begin : g_chk_ch
    assert_busy_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ch_busy[i] |-> ch_enabled[i]);

    assert_indep_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!pair_chain[i/2] && ch_enabled[i] && !ch_busy[i] && ch_req[i]) |=> ch_busy[i]);

    assert_cmpl_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ch_cmpl[i] |-> (!ch_busy[i] && !ch_enabled[i] && ch_blk_done[i]));

    assert_idle_no_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_busy[i] |=> !ch_blk_done[i]);

    assert_handoff_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_chain[i/2] && ch_cmpl[i] && ch_enabled[i^1]) |=> ch_busy[i^1]);
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_chk_pair
    assert_stop_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_chain[p] && ((ch_cmpl[2*p] && !ch_enabled[2*p+1]) ||
                         (ch_cmpl[2*p+1] && !ch_enabled[2*p])))
      |-> !pair_act_vld[p]);

    assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pair_chain[p] |-> !(ch_busy[2*p] && ch_busy[2*p+1]));

    assert_active_sel_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_chain[p] && ch_busy[2*p+1]) |-> (pair_act_vld[p] && pair_act_sel[p]));
  end

endmodule

bind dma_pair_chainer dpc_checker #(.NPAIR(NPAIR)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pair_chain   (pair_chain),
  .ch_req       (ch_req),
  .ch_enabled   (ch_enabled),
  .ch_busy      (ch_busy),
  .ch_blk_done  (ch_blk_done),
  .ch_cmpl      (ch_cmpl),
  .pair_act_vld (pair_act_vld),
  .pair_act_sel (pair_act_sel)
);

// File: tb/sim_dma_pair_chainer.sv
module sim_dma_pair_chainer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  pair_chain;
  logic [3:0]  ch_arm;
  logic [31:0] cfg_blk;
  logic [15:0] cfg_rep;
  logic [3:0]  ch_req;
  logic [3:0]  byte_done;
  logic [3:0]  ch_enabled;
  logic [3:0]  ch_busy;
  logic [3:0]  ch_blk_done;
  logic [3:0]  ch_cmpl;
  logic [1:0]  pair_act_vld;
  logic [1:0]  pair_act_sel;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  dma_pair_chainer u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .pair_chain   (pair_chain),
    .ch_arm       (ch_arm),
    .cfg_blk      (cfg_blk),
    .cfg_rep      (cfg_rep),
    .ch_req       (ch_req),
    .byte_done    (byte_done),
    .ch_enabled   (ch_enabled),
    .ch_busy      (ch_busy),
    .ch_blk_done  (ch_blk_done),
    .ch_cmpl      (ch_cmpl),
    .pair_act_vld (pair_act_vld),
    .pair_act_sel (pair_act_sel)
  );

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic set_cfg(input int ch, input int blk, input int rep);
    cfg_blk[ch*8 +: 8] = 8'(blk);
    cfg_rep[ch*4 +: 4] = 4'(rep);
  endtask

  // One channel, independent mode: arm, request, count to completion.
  task automatic run_single(input int ch, input int blk, input int rep);
    int len   = blk * rep;
    int kc    = -1;
    int nd    = 0;
    int first = -1;
    int late  = 0;
    set_cfg(ch, blk, rep);
    ch_arm[ch] = 1'b1;
    @(negedge clk);
    ch_arm[ch] = 1'b0;
    chk("R2", "enabled after arm", int'(ch_enabled[ch]), 1);
    ch_req[ch] = 1'b1;
    for (int k = 1; k <= len + 4; k++) begin
      @(negedge clk);
      if (k == 1) begin
        ch_req[ch] = 1'b0;
        chk("R3", "busy after request", int'(ch_busy[ch]), 1);
      end
      if (ch_blk_done[ch]) begin
        if (kc < 0) nd++;
        else late++;
        if (first < 0) first = k;
      end
      if (ch_cmpl[ch] && kc < 0) begin
        kc = k;
        chk("R5", "busy at complete", int'(ch_busy[ch]), 0);
        chk("R5", "enable at complete", int'(ch_enabled[ch]), 0);
      end
    end
    chk("R5", "complete cycle", kc, 1 + len);
    chk("R4", "block-done count", nd, rep);
    chk("R4", "first block-done cycle", first, 1 + blk);
    chk("R6", "pulses while idle", late, 0);
  endtask

  initial begin
    rst_n      = 1'b0;
    pair_chain = 2'b00;
    ch_arm     = '0;
    ch_req     = '0;
    cfg_blk    = '0;
    cfg_rep    = '0;
    byte_done  = 4'hF;
    repeat (3) @(negedge clk);
    chk("R1", "enabled in reset", int'(ch_enabled), 0);
    chk("R1", "busy in reset", int'(ch_busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "block-done after reset", int'(ch_blk_done), 0);
    chk("R1", "complete after reset", int'(ch_cmpl), 0);
    chk("R1", "active after reset", int'(pair_act_vld), 0);

    // Sweep every channel over small lengths and repeat counts.
    for (int ch = 0; ch < 4; ch++)
      for (int blk = 1; blk <= 4; blk++)
        for (int rep = 1; rep <= 3; rep++)
          run_single(ch, blk, rep);

    // Arm while busy must not alter the running transfer (R2).
    set_cfg(2, 2, 1);
    ch_arm[2] = 1'b1;
    @(negedge clk);
    ch_arm[2] = 1'b0;
    ch_req[2] = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      ch_arm[2] = 1'b0;
      if (k == 1) begin
        ch_req[2] = 1'b0;
        set_cfg(2, 7, 3);
        ch_arm[2] = 1'b1;
      end
      if (k == 3) chk("R2", "complete with old length", int'(ch_cmpl[2]), 1);
      if (k == 6) chk("R2", "enable after busy arm", int'(ch_enabled[2]), 0);
    end

    // Pair 0 chained, pair 1 independent, started together.
    begin
      int lens [2];
      int n_c      = 0;
      int exp_t    = 7;
      int both     = 0;
      int nxt_k    = -1;
      int nxt_ch   = 0;
      lens[0] = 6;
      lens[1] = 10;
      pair_chain = 2'b01;
      set_cfg(0, 3, 2);
      set_cfg(1, 5, 2);
      set_cfg(2, 2, 1);
      set_cfg(3, 3, 2);
      ch_arm = 4'hF;
      @(negedge clk);
      ch_arm = '0;
      ch_req = 4'hF;
      for (int k = 1; k <= 60; k++) begin
        @(negedge clk);
        ch_arm = '0;
        if (k == 1) begin
          ch_req[3:2] = 2'b00;
          chk("R10", "lower channel started", int'(ch_busy[0]), 1);
          chk("R10", "higher channel held", int'(ch_busy[1]), 0);
          chk("R11", "both independent busy", int'(ch_busy[3:2]), 3);
        end
        if (k == 3) chk("R11", "short independent done", int'(ch_cmpl[2]), 1);
        if (k == 4) ch_arm[2] = 1'b1;
        if (k == 7) chk("R11", "long independent done", int'(ch_cmpl[3]), 1);
        if (k == 9) begin
          chk("R11", "partner not started", int'(ch_busy[2]), 0);
          chk("R11", "partner still enabled", int'(ch_enabled[2]), 1);
        end
        if (ch_busy[0] && ch_busy[1]) both++;
        if (k == nxt_k)
          chk("R7", "partner busy after handoff", int'(ch_busy[nxt_ch]), 1);
        if (ch_cmpl[0] || ch_cmpl[1]) begin
          int who;
          who = ch_cmpl[1] ? 1 : 0;
          n_c++;
          chk("R7", "completing channel", who, (n_c - 1) % 2);
          chk("R7", "completion cycle", k, exp_t);
          if (n_c < 5) begin
            chk("R12", "active valid at handoff", int'(pair_act_vld[0]), 1);
            chk("R12", "active select at handoff", int'(pair_act_sel[0]), 1 - who);
            nxt_k  = k + 1;
            nxt_ch = 1 - who;
          end else begin
            chk("R8", "active idle at stop", int'(pair_act_vld[0]), 0);
          end
          if (n_c <= 3) ch_arm[who] = 1'b1;
          exp_t = exp_t + 1 + lens[1 - who];
        end
      end
      chk("R7", "completions seen", n_c, 5);
      chk("R9", "cycles both busy", both, 0);
      chk("R8", "pair stays stopped", int'(ch_busy[1:0]), 0);
      ch_req = '0;
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule